// File: doc/BRIEF.md
# Instruction Stream Buffer Prefetcher

This block sits between a blocking first-level instruction cache and the next memory level. It serves one cache miss at a time. When a missed block is in neither the cache nor the one-entry stream buffer, it requests the block from memory as a demand fetch. It also requests the following block as a prefetch, which is parked in the stream buffer and never written into the cache directly. A later miss that finds its block in the stream buffer is filled from the buffer with no memory access, and the prefetch of the next block starts at once.

A miss that matches a prefetch already on its way waits for that response and does not fetch the block twice. A miss that matches nothing empties the buffer and restarts the stream from the new block. A prefetch response from the abandoned stream is thrown away when it arrives. When stride mode is on, a small detector looks at the distance between successive miss blocks. Once it has seen two equal non-zero distances in a row, the next prefetch uses that distance instead of one block.

Top module: `sbp_prefetcher`

## Requirements
- R1: While reset is asserted and until the internal reset release completes, `miss_ready`, `fill_valid` and `mreq_valid` are low. After that `miss_ready` is high with no fill and no memory request.
- R2: A miss that matches neither the stream buffer nor an outstanding prefetch produces a memory request for that block with tag 0 (demand). It is then followed by a request for the block plus the step with tag 1 (prefetch). The fill returns the memory data with `fill_pref` = 0.
- R3: When a demand and a prefetch are both waiting, the demand is presented first. A demand request held off by `mreq_ready` low stays valid with an unchanged block.
- R4: A miss that matches the stream buffer is filled in the cycle after acceptance, with the buffered data and `fill_pref` = 1. No demand request is made, the buffer is emptied, and a prefetch of the block plus the step follows.
- R5: A miss to a block whose prefetch is outstanding makes no demand request. It is filled from that prefetch response with `fill_pref` = 1, and the prefetch of the following block is then issued.
- R6: A miss that matches nothing empties the stream buffer. A prefetch response belonging to the abandoned stream is dropped, so a later miss to that block goes to memory as a demand.
- R7: The step is 1 block unless stride mode is on and the last three miss blocks were spaced by the same non-zero distance N. In that case the step is N. A repeated block (distance 0) never arms stride mode.
- R8: A prefetch response flagged with an error is dropped silently: no fill error is raised and the buffer is not loaded. A demand response flagged with an error is passed on as `fill_err` = 1.
- R9: A miss waiting on a prefetch that comes back with an error is re-requested as a demand, and the fill comes from that demand response.
- R10: At most one prefetch is outstanding at the memory port at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stride_mode | input | 1 | 1 enables stride detection for the prefetch step |
| miss_valid | input | 1 | Cache presents a miss |
| miss_ready | output | 1 | Block can accept a miss |
| miss_blk | input | ADDR_W | Block address of the miss |
| fill_valid | output | 1 | One-cycle fill pulse to the cache |
| fill_blk | output | ADDR_W | Block address being filled |
| fill_data | output | DATA_W | Fill data |
| fill_err | output | 1 | Demand fetch returned an error |
| fill_pref | output | 1 | Fill came from the stream buffer or a prefetch response |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_blk | output | ADDR_W | Requested block address |
| mreq_tag | output | 1 | 0 demand, 1 prefetch |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_tag | input | 1 | Tag of the response, 0 demand, 1 prefetch |
| mrsp_data | input | DATA_W | Response data |
| mrsp_err | input | 1 | Response carries an error |

## Verification
The hardest case to reach from the ports is a stale prefetch. A prefetch for the old stream must still be in flight when a new, unrelated miss empties the buffer. The restarted stream's own prefetch then has to wait behind the doomed response. The bench makes the memory model's prefetch latency much longer than its demand latency. It then hits the buffer, which launches a slow prefetch, and at once misses on a distant block. Afterwards it asks for the abandoned block and expects a demand fetch. A similar latency split keeps an erroring prefetch outstanding long enough for a waiting miss to depend on it.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DWAIT,
    ST_PWAIT,
    ST_RESP
  } sbp_state_e;

  localparam logic TAG_DEMAND = 1'b0;
  localparam logic TAG_PREF   = 1'b1;
endpackage

// File: rtl/sbp_stride.sv
module sbp_stride #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] blk_i,
  output logic [ADDR_W-1:0] step_o
);
  localparam logic [ADDR_W-1:0] UNIT = ADDR_W'(1);

  logic [ADDR_W-1:0] last_q, last_n;
  logic [ADDR_W-1:0] dist_q, dist_n;
  logic              seen_q, seen_n;
  logic              hist_q, hist_n;
  logic [ADDR_W-1:0] cur;
  logic              armed;

  assign cur    = blk_i - last_q;
  assign armed  = seen_q && hist_q && (cur == dist_q) && (cur != '0);
  assign step_o = (mode_i && armed) ? cur : UNIT;

  always_comb begin
    last_n = last_q;
    dist_n = dist_q;
    seen_n = seen_q;
    hist_n = hist_q;
    if (obs_i) begin
      last_n = blk_i;
      dist_n = cur;
      seen_n = 1'b1;
      hist_n = seen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      dist_q <= '0;
      seen_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      last_q <= last_n;
      dist_q <= dist_n;
      seen_q <= seen_n;
      hist_q <= hist_n;
    end
  end

  // R7: an armed observation keeps the recorded distance
  a_r7_armed_keeps_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_i && armed) |=> (dist_q == $past(dist_q)));
endmodule

// File: rtl/sbp_buffer.sv
module sbp_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_blk_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              take_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] look_blk_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q, valid_n;
  logic [ADDR_W-1:0] blk_q, blk_n;
  logic [DATA_W-1:0] data_q, data_n;

  assign hit_o  = valid_q && (blk_q == look_blk_i);
  assign data_o = data_q;

  always_comb begin
    valid_n = valid_q;
    blk_n   = blk_q;
    data_n  = data_q;
    if (load_i) begin
      valid_n = 1'b1;
      blk_n   = load_blk_i;
      data_n  = load_data_i;
    end
    if (take_i || flush_i) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      blk_q   <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_n;
      if (load_i) begin
        blk_q  <= blk_n;
        data_q <= data_n;
      end
    end
  end

  // R4: promoting the entry leaves the buffer empty
  a_r4_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !valid_q);
  // R6: a restart leaves the buffer empty
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !valid_q);
endmodule

// File: rtl/sbp_port.sv
module sbp_port #(
  parameter int ADDR_W = 16
) (
  input  logic              d_want_i,
  input  logic [ADDR_W-1:0] d_blk_i,
  input  logic              p_want_i,
  input  logic [ADDR_W-1:0] p_blk_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] blk_o,
  output logic              tag_o,
  output logic              d_fire_o,
  output logic              p_fire_o
);
  import sbp_pkg::*;

  always_comb begin
    valid_o = d_want_i || p_want_i;
    blk_o   = d_want_i ? d_blk_i : p_blk_i;
    tag_o   = d_want_i ? TAG_DEMAND : TAG_PREF;
    d_fire_o = d_want_i && ready_i;
    p_fire_o = !d_want_i && p_want_i && ready_i;
  end
endmodule

// File: rtl/sbp_prefetcher.sv
module sbp_prefetcher #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stride_mode,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_blk,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_blk,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_err,
  output logic              fill_pref,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ADDR_W-1:0] mreq_blk,
  output logic              mreq_tag,
  input  logic              mrsp_valid,
  input  logic              mrsp_tag,
  input  logic [DATA_W-1:0] mrsp_data,
  input  logic              mrsp_err
);
  import sbp_pkg::*;

  localparam int SYNC_STAGES = 2;

  // reset: asynchronous assertion, synchronous release
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rs_n = rsync_q[SYNC_STAGES-1];

  sbp_state_e        st_q, st_n;
  logic [ADDR_W-1:0] cur_q, cur_n;
  logic [ADDR_W-1:0] nxt_q, nxt_n;
  logic              pend_q, pend_n;
  logic [ADDR_W-1:0] tgt_q, tgt_n;
  logic              busy_q, busy_n;
  logic [ADDR_W-1:0] pblk_q, pblk_n;
  logic              stale_q, stale_n;
  logic [DATA_W-1:0] fdata_q, fdata_n;
  logic              ferr_q, ferr_n;
  logic              fpref_q, fpref_n;

  logic              acc;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] acc_tgt;
  logic              buf_hit;
  logic [DATA_W-1:0] buf_data;
  logic              buf_load, buf_take, buf_flush;
  logic              d_fire, p_fire;
  logic              pref_rsp, dem_rsp, pf_good;

  assign acc      = miss_valid && miss_ready;
  assign acc_tgt  = miss_blk + step;
  assign pref_rsp = mrsp_valid && (mrsp_tag == TAG_PREF);
  assign dem_rsp  = mrsp_valid && (mrsp_tag == TAG_DEMAND);
  assign pf_good  = pref_rsp && !stale_q && !mrsp_err;

  sbp_stride #(.ADDR_W(ADDR_W)) u_stride (
    .clk    (clk),
    .rst_n  (rs_n),
    .obs_i  (acc),
    .mode_i (stride_mode),
    .blk_i  (miss_blk),
    .step_o (step)
  );

  sbp_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk         (clk),
    .rst_n       (rs_n),
    .load_i      (buf_load),
    .load_blk_i  (pblk_q),
    .load_data_i (mrsp_data),
    .take_i      (buf_take),
    .flush_i     (buf_flush),
    .look_blk_i  (miss_blk),
    .hit_o       (buf_hit),
    .data_o      (buf_data)
  );

  sbp_port #(.ADDR_W(ADDR_W)) u_port (
    .d_want_i (st_q == ST_DREQ),
    .d_blk_i  (cur_q),
    .p_want_i (pend_q && !busy_q),
    .p_blk_i  (tgt_q),
    .ready_i  (mreq_ready),
    .valid_o  (mreq_valid),
    .blk_o    (mreq_blk),
    .tag_o    (mreq_tag),
    .d_fire_o (d_fire),
    .p_fire_o (p_fire)
  );

  assign miss_ready = rs_n && (st_q == ST_IDLE);
  assign fill_valid = (st_q == ST_RESP);
  assign fill_blk   = cur_q;
  assign fill_data  = fdata_q;
  assign fill_err   = ferr_q;
  assign fill_pref  = fpref_q;

  always_comb begin
    st_n    = st_q;
    cur_n   = cur_q;
    nxt_n   = nxt_q;
    pend_n  = pend_q;
    tgt_n   = tgt_q;
    busy_n  = busy_q;
    pblk_n  = pblk_q;
    stale_n = stale_q;
    fdata_n = fdata_q;
    ferr_n  = ferr_q;
    fpref_n = fpref_q;
    buf_take  = 1'b0;
    buf_flush = 1'b0;
    buf_load  = pf_good && (st_q != ST_PWAIT) && !acc;

    if (p_fire) begin
      pend_n  = 1'b0;
      busy_n  = 1'b1;
      pblk_n  = tgt_q;
      stale_n = 1'b0;
    end
    if (pref_rsp) begin
      busy_n  = 1'b0;
      stale_n = 1'b0;
    end

    unique case (st_q)
      ST_IDLE: begin
        if (acc) begin
          cur_n = miss_blk;
          if (buf_hit) begin
            buf_take = 1'b1;
            fdata_n  = buf_data;
            ferr_n   = 1'b0;
            fpref_n  = 1'b1;
            st_n     = ST_RESP;
            pend_n   = 1'b1;
            tgt_n    = acc_tgt;
          end else if (pf_good && (pblk_q == miss_blk)) begin
            fdata_n = mrsp_data;
            ferr_n  = 1'b0;
            fpref_n = 1'b1;
            st_n    = ST_RESP;
            pend_n  = 1'b1;
            tgt_n   = acc_tgt;
          end else if ((busy_q && !stale_q && !pref_rsp && (pblk_q == miss_blk)) ||
                       (p_fire && (tgt_q == miss_blk))) begin
            nxt_n = acc_tgt;
            st_n  = ST_PWAIT;
          end else begin
            buf_flush = 1'b1;
            if ((busy_q && !pref_rsp) || p_fire) stale_n = 1'b1;
            st_n   = ST_DREQ;
            pend_n = 1'b1;
            tgt_n  = acc_tgt;
          end
        end
      end
      ST_DREQ: begin
        if (d_fire) st_n = ST_DWAIT;
      end
      ST_DWAIT: begin
        if (dem_rsp) begin
          fdata_n = mrsp_data;
          ferr_n  = mrsp_err;
          fpref_n = 1'b0;
          st_n    = ST_RESP;
        end
      end
      ST_PWAIT: begin
        if (pref_rsp) begin
          pend_n = 1'b1;
          tgt_n  = nxt_q;
          if (mrsp_err) begin
            st_n = ST_DREQ;
          end else begin
            fdata_n = mrsp_data;
            ferr_n  = 1'b0;
            fpref_n = 1'b1;
            st_n    = ST_RESP;
          end
        end
      end
      ST_RESP: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      pend_q  <= 1'b0;
      tgt_q   <= '0;
      busy_q  <= 1'b0;
      pblk_q  <= '0;
      stale_q <= 1'b0;
      fdata_q <= '0;
      ferr_q  <= 1'b0;
      fpref_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cur_q   <= cur_n;
      nxt_q   <= nxt_n;
      pend_q  <= pend_n;
      tgt_q   <= tgt_n;
      busy_q  <= busy_n;
      pblk_q  <= pblk_n;
      stale_q <= stale_n;
      fdata_q <= fdata_n;
      ferr_q  <= ferr_n;
      fpref_q <= fpref_n;
    end
  end

  // R1: nothing is offered to either side during reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rs_n |-> (!miss_ready && !mreq_valid));
  // R2: a fill pulse lasts one cycle and reopens the miss port
  a_r2_fill_reopens: assert property (@(posedge clk) disable iff (!rs_n)
    fill_valid |=> (miss_ready && !fill_valid));
  // R3: a pending demand keeps prefetches off the port
  a_r3_demand_priority: assert property (@(posedge clk) disable iff (!rs_n)
    (st_q == ST_DREQ) |-> (mreq_valid && mreq_tag == TAG_DEMAND));
  // R3: a stalled demand request holds its block
  a_r3_demand_hold: assert property (@(posedge clk) disable iff (!rs_n)
    (mreq_valid && mreq_tag == TAG_DEMAND && !mreq_ready) |=>
      (mreq_valid && mreq_tag == TAG_DEMAND && $stable(mreq_blk)));
  // R10: a prefetch is only sent when none is outstanding
  a_r10_single_prefetch: assert property (@(posedge clk) disable iff (!rs_n)
    (mreq_valid && mreq_ready && mreq_tag == TAG_PREF) |-> !busy_q);
endmodule

// File: tb/sbp_prefetcher_test.sv
`timescale 1ns/1ps
module sbp_prefetcher_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stride_mode;
  logic          miss_valid;
  logic          miss_ready;
  logic [AW-1:0] miss_blk;
  logic          fill_valid;
  logic [AW-1:0] fill_blk;
  logic [DW-1:0] fill_data;
  logic          fill_err;
  logic          fill_pref;
  logic          mreq_valid;
  logic          mreq_ready;
  logic [AW-1:0] mreq_blk;
  logic          mreq_tag;
  logic          mrsp_valid;
  logic          mrsp_tag;
  logic [DW-1:0] mrsp_data;
  logic          mrsp_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // memory model controls, written by the scenario tasks only
  int      dlat = 3;
  int      plat = 2;
  logic [AW-1:0] err_blk = '1;
  bit      err_pf_only = 1'b0;
  int      log_base = 0;

  // memory model state, written by the model only
  logic [AW-1:0] log_blk [0:255];
  logic          log_tag [0:255];
  int      log_n = 0;
  int      vio = 0;
  bit      d_act = 0, p_act = 0;
  int      d_cnt = 0, p_cnt = 0;
  logic [AW-1:0] d_blk = '0, p_blk = '0;

  always #2.5 clk = ~clk;

  sbp_prefetcher #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .stride_mode(stride_mode),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_blk(miss_blk),
    .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_data(fill_data),
    .fill_err(fill_err), .fill_pref(fill_pref),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_blk(mreq_blk),
    .mreq_tag(mreq_tag), .mrsp_valid(mrsp_valid), .mrsp_tag(mrsp_tag),
    .mrsp_data(mrsp_data), .mrsp_err(mrsp_err)
  );

  function automatic logic [DW-1:0] mdata(input logic [AW-1:0] b);
    return (DW'(b) * 32'd2654435) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic bit blk_err(input logic [AW-1:0] b, input logic t);
    return (b == err_blk) && (t == 1'b1 || !err_pf_only);
  endfunction

  always @(negedge clk) begin
    mrsp_valid = 1'b0;
    mrsp_err   = 1'b0;
    if (d_act) begin
      if (d_cnt == 0) begin
        mrsp_valid = 1'b1; mrsp_tag = 1'b0;
        mrsp_data = mdata(d_blk); mrsp_err = blk_err(d_blk, 1'b0);
        d_act = 0;
      end else d_cnt--;
    end
    if (p_act) begin
      if (p_cnt == 0) begin
        if (!mrsp_valid) begin
          mrsp_valid = 1'b1; mrsp_tag = 1'b1;
          mrsp_data = mdata(p_blk); mrsp_err = blk_err(p_blk, 1'b1);
          p_act = 0;
        end
      end else p_cnt--;
    end
    if (mreq_valid && mreq_ready) begin
      if (log_n < 256) begin
        log_blk[log_n] = mreq_blk;
        log_tag[log_n] = mreq_tag;
        log_n++;
      end
      if (mreq_tag) begin
        if (p_act) vio++;
        p_act = 1; p_blk = mreq_blk; p_cnt = plat;
      end else begin
        if (d_act) vio++;
        d_act = 1; d_blk = mreq_blk; d_cnt = dlat;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit logged(input logic [AW-1:0] b, input logic t);
    for (int i = log_base; i < log_n; i++)
      if (log_blk[i] == b && log_tag[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int n_demand();
    int c = 0;
    for (int i = log_base; i < log_n; i++) if (!log_tag[i]) c++;
    return c;
  endfunction

  function automatic logic [AW-1:0] last_pf();
    logic [AW-1:0] r = '1;
    for (int i = log_base; i < log_n; i++) if (log_tag[i]) r = log_blk[i];
    return r;
  endfunction

  task automatic do_miss(input logic [AW-1:0] b, input bit exp_pref, input bit exp_err,
                         input string req, output int cyc);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_blk   = b;
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    cyc = 1;
    while (!fill_valid) begin
      @(negedge clk);
      cyc++;
    end
    chk(fill_blk == b, req, "fill block", DW'(fill_blk), DW'(b));
    chk(fill_pref == exp_pref, req, "fill source", DW'(fill_pref), DW'(exp_pref));
    chk(fill_err == exp_err, req, "fill error", DW'(fill_err), DW'(exp_err));
    if (!exp_err) chk(fill_data == mdata(b), req, "fill data", fill_data, mdata(b));
  endtask

  task automatic t_reset();
    chk(!miss_ready && !fill_valid && !mreq_valid, "R1", "outputs in reset",
        DW'({miss_ready, fill_valid, mreq_valid}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    chk(miss_ready && !fill_valid && !mreq_valid, "R1", "outputs after reset",
        DW'({miss_ready, fill_valid, mreq_valid}), 32'h4);
  endtask

  task automatic t_cold_miss();
    int c;
    log_base = log_n;
    do_miss(16'd100, 1'b0, 1'b0, "R2", c);
    idle(10);
    chk(log_n - log_base == 2, "R2", "request count", DW'(log_n - log_base), 2);
    chk(log_blk[log_base] == 16'd100 && log_tag[log_base] == 1'b0, "R3", "demand first",
        DW'({log_tag[log_base], log_blk[log_base]}), 32'd100);
    chk(log_blk[log_base+1] == 16'd101 && log_tag[log_base+1] == 1'b1, "R2", "next-block prefetch",
        DW'({log_tag[log_base+1], log_blk[log_base+1]}), 32'h10065);
  endtask

  task automatic t_buffer_hit();
    int c;
    log_base = log_n;
    do_miss(16'd101, 1'b1, 1'b0, "R4", c);
    chk(c == 1, "R4", "fill latency", DW'(c), 1);
    idle(10);
    chk(n_demand() == 0, "R4", "demand requests", DW'(n_demand()), 0);
    chk(logged(16'd102, 1'b1), "R4", "prefetch of following block", DW'(last_pf()), 32'd102);
  endtask

  task automatic t_inflight();
    int c;
    plat = 20;
    log_base = log_n;
    do_miss(16'd102, 1'b1, 1'b0, "R4", c);
    do_miss(16'd103, 1'b1, 1'b0, "R5", c);
    idle(40);
    chk(n_demand() == 0, "R5", "no duplicate demand", DW'(n_demand()), 0);
    chk(last_pf() == 16'd104, "R5", "prefetch after wait", DW'(last_pf()), 32'd104);
  endtask

  task automatic t_stale();
    int c;
    plat = 30;
    do_miss(16'd104, 1'b1, 1'b0, "R4", c);
    log_base = log_n;
    do_miss(16'd200, 1'b0, 1'b0, "R6", c);
    idle(60);
    chk(logged(16'd201, 1'b1), "R6", "restarted stream prefetch", DW'(last_pf()), 32'd201);
    log_base = log_n;
    plat = 2;
    do_miss(16'd105, 1'b0, 1'b0, "R6", c);
    idle(10);
    chk(logged(16'd105, 1'b0), "R6", "stale block fetched as demand", DW'(n_demand()), 1);
  endtask

  task automatic t_stride();
    int c;
    stride_mode = 1'b1;
    do_miss(16'd300, 1'b0, 1'b0, "R7", c);
    idle(8);
    log_base = log_n;
    do_miss(16'd304, 1'b0, 1'b0, "R7", c);
    idle(8);
    chk(last_pf() == 16'd305, "R7", "unarmed step", DW'(last_pf()), 32'd305);
    log_base = log_n;
    do_miss(16'd308, 1'b0, 1'b0, "R7", c);
    idle(8);
    chk(last_pf() == 16'd312, "R7", "armed stride prefetch", DW'(last_pf()), 32'd312);
    log_base = log_n;
    do_miss(16'd312, 1'b1, 1'b0, "R7", c);
    idle(8);
    chk(last_pf() == 16'd316, "R7", "stride after buffer hit", DW'(last_pf()), 32'd316);
    do_miss(16'd400, 1'b0, 1'b0, "R7", c);
    idle(8);
    do_miss(16'd400, 1'b0, 1'b0, "R7", c);
    idle(8);
    log_base = log_n;
    do_miss(16'd400, 1'b0, 1'b0, "R7", c);
    idle(8);
    chk(last_pf() == 16'd401, "R7", "zero distance never arms", DW'(last_pf()), 32'd401);
    stride_mode = 1'b0;
    do_miss(16'd500, 1'b0, 1'b0, "R7", c);
    idle(8);
    do_miss(16'd504, 1'b0, 1'b0, "R7", c);
    idle(8);
    log_base = log_n;
    do_miss(16'd508, 1'b0, 1'b0, "R7", c);
    idle(8);
    chk(last_pf() == 16'd509, "R7", "stride mode off", DW'(last_pf()), 32'd509);
  endtask

  task automatic t_errors();
    int c;
    err_blk = 16'd601;
    err_pf_only = 1'b0;
    do_miss(16'd600, 1'b0, 1'b0, "R8", c);
    idle(10);
    log_base = log_n;
    do_miss(16'd601, 1'b0, 1'b1, "R8", c);
    idle(6);
    chk(logged(16'd601, 1'b0), "R8", "errored prefetch not buffered", DW'(n_demand()), 1);
    err_blk = 16'd701;
    err_pf_only = 1'b1;
    plat = 20;
    do_miss(16'd700, 1'b0, 1'b0, "R9", c);
    log_base = log_n;
    do_miss(16'd701, 1'b0, 1'b0, "R9", c);
    idle(30);
    chk(logged(16'd701, 1'b0), "R9", "re-request as demand", DW'(n_demand()), 1);
    chk(vio == 0, "R10", "overlapping requests of one kind", DW'(vio), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    stride_mode = 1'b0;
    miss_valid = 1'b0;
    miss_blk = '0;
    mreq_ready = 1'b1;
    idle(3);
    t_reset();
    t_cold_miss();
    t_buffer_hit();
    t_inflight();
    t_stale();
    t_stride();
    t_errors();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule